// File: doc/BRIEF.md
# Floating-Point Stack Opcode Decoder

This block turns one floating-point escape instruction into a control bundle for a stack-based floating-point datapath. Its inputs are the three low bits of the escape opcode (escape number 0 to 7), the ModR/M byte and a flag that says whether the ModR/M byte names a memory operand or a stack register. The bundle carries the operation class, a function selector for constants and transcendental functions, source and destination stack offsets relative to the top, the memory operand format, a push request, a pop count of 0 to 2, an invalid flag, and three store requests: status word to memory, status word to the accumulator register, and control word to memory.

The decoder works out the whole irregular escape map. This includes the reversed-operand register forms, in which subtract and divide swap with their reversed twins, and the forms that pop once or twice without saying so. Encodings that have no meaning raise the invalid flag and request nothing. The decode logic is combinational. A parameter selects an output register behind a two-state controller. In the idle state `ST_IDLE` no bundle is presented. A strobe on `in_valid` moves the controller to the emit state `ST_EMIT`, where the registered bundle is presented for one cycle. A further strobe keeps it in `ST_EMIT` and presents the new bundle. A cycle without a strobe returns it to `ST_IDLE`, and the last bundle is held.

Top module: `fpu_esc_decoder`

## Requirements
- R1: The group field is ModR/M bits 5:3 and the sub field is bits 2:0. In register forms the sub field is the stack index i of ST(i), and it appears in `src_off` or `dst_off` as the operation needs. Arithmetic and compares with ST(0) as destination give dst 0 and src i.
- R2: In memory form, escapes 0, 2, 4 and 6 use the formats 32-bit real, 32-bit integer, 64-bit real and 16-bit integer. Groups 0 to 7 map to add, mul, compare, compare, sub, subr, div and divr. Group 3 pops once. Offsets are 0.
- R3: In escape 4 register form, arithmetic writes ST(i) (dst = sub, src = 0). Groups 4, 5, 6 and 7 are subr, sub, divr and div. Groups 2 and 3 compare ST(0) with ST(i), and group 3 pops once.
- R4: Escape 6 register forms decode like escape 4 and add one pop. Group 3 is valid only with sub 1, where it compares with ST(1) and pops twice. The pop count never exceeds 2.
- R5: In escape 2 register form, only group 5 sub 1 is valid. It is an unordered compare of ST(0) with ST(1) and pops twice.
- R6: In escape 1 register form, group 5 sub 0 to 6 is a constant load with a push and `func_sel` = sub. Sub 7 is invalid.
- R7: In escape 1 register form, group 6 sub 6 and sub 7 decrement and increment the stack top. Sub 0 to 5 of group 6 are transcendental with `func_sel` = sub, and group 7 is transcendental with `func_sel` = 8 + sub. Group 4 sub 0, 1, 4 and 5 are change-sign, absolute, test and examine, and its other subs are invalid.
- R8: In escape 7 memory form, groups 4 and 5 load packed BCD and 64-bit integer with a push. Groups 6 and 7 store packed BCD and 64-bit integer and pop once.
- R9: Escape 7 register form group 4 sub 0 raises `store_sw_ax`. Escape 5 memory form group 7 raises `store_sw_mem`, and escape 1 memory form group 7 raises `store_cw_mem`. At most one store request is high at any time.
- R10: In escape 3 register form, group 4 sub 2 is clear-exceptions, sub 3 is initialize, and sub 4 and sub 5 are no-ops. Every other escape 3 register encoding is invalid.
- R11: An invalid encoding gives `invalid` = 1, op class none, format none, zero offsets, no push, pop count 0 and no store request.
- R12: With the output register, the bundle of a strobe appears one cycle later with `out_valid` high. `out_valid` is low in the cycle after a cycle with no strobe, and the bundle holds its value then. After reset `out_valid` is low and the bundle is all zero.
- R13: An encoding that pushes never pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode strobe |
| esc_num | input | 3 | Escape number (low opcode bits) |
| modrm | input | 8 | ModR/M byte |
| mem_form | input | 1 | 1 = memory operand form, 0 = register form |
| out_valid | output | 1 | Bundle valid |
| op_class | output | 5 | Operation class code (package enumeration) |
| func_sel | output | 4 | Constant or transcendental function selector |
| src_off | output | 3 | Source stack offset |
| dst_off | output | 3 | Destination stack offset |
| mem_fmt | output | 4 | Memory operand format code (package enumeration) |
| push_req | output | 1 | Push before the operation |
| pop_cnt | output | 2 | Pops after the operation |
| invalid | output | 1 | Undefined encoding |
| store_sw_mem | output | 1 | Store status word to memory |
| store_sw_ax | output | 1 | Copy status word to the accumulator register |
| store_cw_mem | output | 1 | Store control word to memory |

## Verification
The controller has only two states, so a wrong state shows at once as `out_valid` high or low in the wrong cycle. It also shows as a bundle that changes during a cycle without a strobe, one cycle after the fault. A decode fault is confined to one escape, form and group slot. That is why all 4096 combinations of escape, form and ModR/M are compared, each one cycle after its strobe. A swapped reversed pair, a missing implicit pop or an unflagged slot therefore shows up on the very encoding that carries it.

// File: rtl/fpu_esc_pkg.sv
package fpu_esc_pkg;

    localparam int ESC_W  = 3;
    localparam int FLD_W  = 3;
    localparam int POP_W  = 2;
    localparam int FUNC_W = 4;
    localparam int OP_W   = 5;
    localparam int FMT_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE, OP_ADD, OP_MUL, OP_COM, OP_SUB, OP_SUBR, OP_DIV, OP_DIVR,
        OP_UCOM, OP_LOAD, OP_STORE, OP_XCH, OP_NOP, OP_CHS, OP_ABS, OP_TST,
        OP_XAM, OP_CONST, OP_TRANS, OP_DECTOP, OP_INCTOP, OP_FREE, OP_CLEX,
        OP_INIT, OP_LDENV, OP_STENV, OP_LDCW, OP_STCW, OP_RSTOR, OP_SAVE, OP_STSW
    } op_class_e;

    typedef enum logic [FMT_W-1:0] {
        MF_NONE, MF_I16, MF_I32, MF_I64, MF_F32, MF_F64, MF_F80, MF_BCD,
        MF_WORD, MF_ENV, MF_STATE
    } mem_fmt_e;

    typedef struct packed {
        op_class_e         op;
        logic [FUNC_W-1:0] func;
        logic [FLD_W-1:0]  src;
        logic [FLD_W-1:0]  dst;
        mem_fmt_e          fmt;
        logic              push;
        logic [POP_W-1:0]  pops;
        logic              invalid;
        logic              sw_mem;
        logic              sw_ax;
        logic              cw_mem;
    } dec_bundle_t;

    // Group arithmetic; rev swaps the reversed pairs in groups 4..7.
    function automatic op_class_e arith_op(input logic [FLD_W-1:0] grp, input logic rev);
        logic [FLD_W-1:0] k;
        op_class_e        op;
        k = (rev && grp[2]) ? {grp[2:1], ~grp[0]} : grp;
        case (k)
            3'd0:        op = OP_ADD;
            3'd1:        op = OP_MUL;
            3'd2, 3'd3:  op = OP_COM;
            3'd4:        op = OP_SUB;
            3'd5:        op = OP_SUBR;
            3'd6:        op = OP_DIV;
            default:     op = OP_DIVR;
        endcase
        return op;
    endfunction

    function automatic dec_bundle_t bad_bundle();
        dec_bundle_t b;
        b         = '0;
        b.invalid = 1'b1;
        return b;
    endfunction

endpackage

// File: rtl/fpu_esc_mem_dec.sv
module fpu_esc_mem_dec
    import fpu_esc_pkg::*;
(
    input  logic [ESC_W-1:0] esc,
    input  logic [FLD_W-1:0] grp,
    output dec_bundle_t      bundle
);

    mem_fmt_e base_fmt;

    always_comb begin
        unique case (esc[2:1])
            2'd0:    base_fmt = esc[0] ? MF_F32 : MF_F32;
            2'd1:    base_fmt = MF_I32;
            2'd2:    base_fmt = MF_F64;
            default: base_fmt = MF_I16;
        endcase
    end

    always_comb begin
        bundle = '0;
        if (!esc[0]) begin
            // escapes 0/2/4/6: load operand, then group arithmetic
            bundle.op   = arith_op(grp, 1'b0);
            bundle.fmt  = base_fmt;
            bundle.pops = (grp == 3'd3) ? 2'd1 : 2'd0;
        end else if (!grp[2]) begin
            // escapes 1/3/5/7, groups 0..3: load / gap / store / store+pop
            bundle.fmt = base_fmt;
            unique case (grp[1:0])
                2'd0: begin bundle.op = OP_LOAD;  bundle.push = 1'b1; end
                2'd1: bundle = bad_bundle();
                2'd2: bundle.op = OP_STORE;
                default: begin bundle.op = OP_STORE; bundle.pops = 2'd1; end
            endcase
        end else begin
            unique case ({esc[2:1], grp[1:0]})
                4'b00_00: begin bundle.op = OP_LDENV; bundle.fmt = MF_ENV;  end
                4'b00_01: begin bundle.op = OP_LDCW;  bundle.fmt = MF_WORD; end
                4'b00_10: begin bundle.op = OP_STENV; bundle.fmt = MF_ENV;  end
                4'b00_11: begin bundle.op = OP_STCW;  bundle.fmt = MF_WORD; bundle.cw_mem = 1'b1; end
                4'b01_01: begin bundle.op = OP_LOAD;  bundle.fmt = MF_F80;  bundle.push = 1'b1; end
                4'b01_11: begin bundle.op = OP_STORE; bundle.fmt = MF_F80;  bundle.pops = 2'd1; end
                4'b10_00: begin bundle.op = OP_RSTOR; bundle.fmt = MF_STATE; end
                4'b10_10: begin bundle.op = OP_SAVE;  bundle.fmt = MF_STATE; end
                4'b10_11: begin bundle.op = OP_STSW;  bundle.fmt = MF_WORD; bundle.sw_mem = 1'b1; end
                4'b11_00: begin bundle.op = OP_LOAD;  bundle.fmt = MF_BCD;  bundle.push = 1'b1; end
                4'b11_01: begin bundle.op = OP_LOAD;  bundle.fmt = MF_I64;  bundle.push = 1'b1; end
                4'b11_10: begin bundle.op = OP_STORE; bundle.fmt = MF_BCD;  bundle.pops = 2'd1; end
                4'b11_11: begin bundle.op = OP_STORE; bundle.fmt = MF_I64;  bundle.pops = 2'd1; end
                default:  bundle = bad_bundle();
            endcase
        end
    end

endmodule

// File: rtl/fpu_esc_reg_dec.sv
module fpu_esc_reg_dec
    import fpu_esc_pkg::*;
(
    input  logic [ESC_W-1:0] esc,
    input  logic [FLD_W-1:0] grp,
    input  logic [FLD_W-1:0] sub,
    output dec_bundle_t      bundle
);

    always_comb begin
        bundle = '0;
        unique case (esc)
            3'd0: begin
                bundle.op   = arith_op(grp, 1'b0);
                bundle.src  = sub;
                bundle.pops = (grp == 3'd3) ? 2'd1 : 2'd0;
            end
            3'd1: begin
                unique case (grp)
                    3'd0: begin bundle.op = OP_LOAD; bundle.src = sub; bundle.push = 1'b1; end
                    3'd1: begin bundle.op = OP_XCH;  bundle.src = sub; end
                    3'd2: bundle.op = OP_NOP;
                    3'd3: begin bundle.op = OP_STORE; bundle.dst = sub; bundle.pops = 2'd1; end
                    3'd4: begin
                        case (sub)
                            3'd0:    bundle.op = OP_CHS;
                            3'd1:    bundle.op = OP_ABS;
                            3'd4:    bundle.op = OP_TST;
                            3'd5:    bundle.op = OP_XAM;
                            default: bundle = bad_bundle();
                        endcase
                    end
                    3'd5: begin
                        if (sub == 3'd7) begin
                            bundle = bad_bundle();
                        end else begin
                            bundle.op   = OP_CONST;
                            bundle.func = {1'b0, sub};
                            bundle.push = 1'b1;
                        end
                    end
                    3'd6: begin
                        case (sub)
                            3'd6:    bundle.op = OP_DECTOP;
                            3'd7:    bundle.op = OP_INCTOP;
                            default: begin bundle.op = OP_TRANS; bundle.func = {1'b0, sub}; end
                        endcase
                    end
                    default: begin bundle.op = OP_TRANS; bundle.func = {1'b1, sub}; end
                endcase
            end
            3'd2: begin
                if (grp == 3'd5 && sub == 3'd1) begin
                    bundle.op   = OP_UCOM;
                    bundle.src  = 3'd1;
                    bundle.pops = 2'd2;
                end else begin
                    bundle = bad_bundle();
                end
            end
            3'd3: begin
                if (grp == 3'd4 && sub == 3'd2)                       bundle.op = OP_CLEX;
                else if (grp == 3'd4 && sub == 3'd3)                  bundle.op = OP_INIT;
                else if (grp == 3'd4 && (sub == 3'd4 || sub == 3'd5)) bundle.op = OP_NOP;
                else                                                  bundle = bad_bundle();
            end
            3'd4, 3'd6: begin
                bundle.op = arith_op(grp, 1'b1);
                if (grp == 3'd2 || grp == 3'd3) bundle.src = sub;
                else                            bundle.dst = sub;
                bundle.pops = {1'b0, grp == 3'd3} + {1'b0, esc[1]};
                if (esc[1] && grp == 3'd3) begin
                    if (sub == 3'd1) begin
                        bundle.src  = 3'd1;
                        bundle.pops = 2'd2;
                    end else begin
                        bundle = bad_bundle();
                    end
                end
            end
            3'd5: begin
                unique case (grp)
                    3'd0: begin bundle.op = OP_FREE;  bundle.dst = sub; end
                    3'd1: begin bundle.op = OP_XCH;   bundle.src = sub; end
                    3'd2: begin bundle.op = OP_STORE; bundle.dst = sub; end
                    3'd3: begin bundle.op = OP_STORE; bundle.dst = sub; bundle.pops = 2'd1; end
                    3'd4: begin bundle.op = OP_UCOM;  bundle.src = sub; end
                    3'd5: begin bundle.op = OP_UCOM;  bundle.src = sub; bundle.pops = 2'd1; end
                    default: bundle = bad_bundle();
                endcase
            end
            default: begin
                unique case (grp)
                    3'd0: begin bundle.op = OP_FREE; bundle.dst = sub; bundle.pops = 2'd1; end
                    3'd1: begin bundle.op = OP_XCH;  bundle.src = sub; end
                    3'd2, 3'd3: begin bundle.op = OP_STORE; bundle.dst = sub; bundle.pops = 2'd1; end
                    3'd4: begin
                        if (sub == 3'd0) begin
                            bundle.op    = OP_STSW;
                            bundle.sw_ax = 1'b1;
                        end else begin
                            bundle = bad_bundle();
                        end
                    end
                    default: bundle = bad_bundle();
                endcase
            end
        endcase
    end

endmodule

// File: rtl/fpu_esc_decoder.sv
module fpu_esc_decoder
    import fpu_esc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ESC_W-1:0]  esc_num,
    input  logic [7:0]        modrm,
    input  logic              mem_form,
    output logic              out_valid,
    output logic [OP_W-1:0]   op_class,
    output logic [FUNC_W-1:0] func_sel,
    output logic [FLD_W-1:0]  src_off,
    output logic [FLD_W-1:0]  dst_off,
    output logic [FMT_W-1:0]  mem_fmt,
    output logic              push_req,
    output logic [POP_W-1:0]  pop_cnt,
    output logic              invalid,
    output logic              store_sw_mem,
    output logic              store_sw_ax,
    output logic              store_cw_mem
);

    localparam int GRP_LSB = FLD_W;

    logic [FLD_W-1:0] grp;
    logic [FLD_W-1:0] sub;
    dec_bundle_t      mem_b;
    dec_bundle_t      reg_b;
    dec_bundle_t      dec_b;
    dec_bundle_t      out_b;

    assign grp = modrm[GRP_LSB +: FLD_W];
    assign sub = modrm[FLD_W-1:0];

    fpu_esc_mem_dec u_mem (.esc(esc_num), .grp(grp), .bundle(mem_b));
    fpu_esc_reg_dec u_reg (.esc(esc_num), .grp(grp), .sub(sub), .bundle(reg_b));

    assign dec_b = mem_form ? mem_b : reg_b;

    generate
        if (REG_OUT) begin : g_reg
            typedef enum logic {ST_IDLE, ST_EMIT} state_e;
            state_e      state_q, state_d;
            dec_bundle_t bundle_q;

            always_comb begin
                unique case (state_q)
                    ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
                    ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) state_q <= ST_IDLE;
                else        state_q <= state_d;
            end

            always_ff @(posedge clk) begin
                if (!rst_n)        bundle_q <= '0;
                else if (in_valid) bundle_q <= dec_b;
            end

            assign out_valid = (state_q == ST_EMIT);
            assign out_b     = bundle_q;

            AST_STROBE_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid) else $error("strobe not emitted"); // R12
            AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid) else $error("spurious valid"); // R12
            AST_HOLD_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(bundle_q)) else $error("bundle moved"); // R12
            AST_PUSH_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && bundle_q.push |-> bundle_q.pops == '0) else $error("push with pop"); // R13
            AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && bundle_q.invalid |-> !bundle_q.push && bundle_q.pops == '0 &&
                !bundle_q.sw_mem && !bundle_q.sw_ax && !bundle_q.cw_mem) else $error("invalid not quiet"); // R11
            AST_POP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
                bundle_q.pops != 2'd3) else $error("pop count 3"); // R4
            AST_ONE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({bundle_q.sw_mem, bundle_q.sw_ax, bundle_q.cw_mem})) else $error("two stores"); // R9
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_b     = dec_b;
        end
    endgenerate

    assign op_class     = out_b.op;
    assign func_sel     = out_b.func;
    assign src_off      = out_b.src;
    assign dst_off      = out_b.dst;
    assign mem_fmt      = out_b.fmt;
    assign push_req     = out_b.push;
    assign pop_cnt      = out_b.pops;
    assign invalid      = out_b.invalid;
    assign store_sw_mem = out_b.sw_mem;
    assign store_sw_ax  = out_b.sw_ax;
    assign store_cw_mem = out_b.cw_mem;

endmodule

// File: tb/fpu_esc_decoder_tb.sv
`timescale 1ns/1ps
module fpu_esc_decoder_tb;
    import fpu_esc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] esc_num = '0;
    logic [7:0] modrm = '0;
    logic       mem_form = 1'b0;
    logic       out_valid;
    logic [4:0] op_class;
    logic [3:0] func_sel;
    logic [2:0] src_off, dst_off;
    logic [3:0] mem_fmt;
    logic       push_req;
    logic [1:0] pop_cnt;
    logic       invalid, store_sw_mem, store_sw_ax, store_cw_mem;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    dec_bundle_t last_exp;

    always #5 clk = ~clk;

    fpu_esc_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esc_num(esc_num),
        .modrm(modrm), .mem_form(mem_form), .out_valid(out_valid),
        .op_class(op_class), .func_sel(func_sel), .src_off(src_off),
        .dst_off(dst_off), .mem_fmt(mem_fmt), .push_req(push_req),
        .pop_cnt(pop_cnt), .invalid(invalid), .store_sw_mem(store_sw_mem),
        .store_sw_ax(store_sw_ax), .store_cw_mem(store_cw_mem)
    );

    function automatic dec_bundle_t mk(op_class_e op, mem_fmt_e fmt, int src, int dst, bit push, int pops);
        dec_bundle_t r;
        r      = '0;
        r.op   = op;
        r.fmt  = fmt;
        r.src  = 3'(src);
        r.dst  = 3'(dst);
        r.push = push;
        r.pops = 2'(pops);
        return r;
    endfunction

    function automatic dec_bundle_t ref_dec(logic [2:0] e, logic m, logic [7:0] rm);
        dec_bundle_t r;
        logic [2:0]  g, s;
        mem_fmt_e    mf;
        op_class_e   fwd [8];
        op_class_e   rev [8];
        fwd = '{OP_ADD, OP_MUL, OP_COM, OP_COM, OP_SUB, OP_SUBR, OP_DIV, OP_DIVR};
        rev = '{OP_ADD, OP_MUL, OP_COM, OP_COM, OP_SUBR, OP_SUB, OP_DIVR, OP_DIV};
        g = rm[5:3];
        s = rm[2:0];
        r = '0;
        r.invalid = 1'b1;
        if (m) begin
            mf = (e[2:1] == 0) ? MF_F32 : (e[2:1] == 1) ? MF_I32 : (e[2:1] == 2) ? MF_F64 : MF_I16;
            if (!e[0])
                r = mk(fwd[g], mf, 0, 0, 0, g == 3);
            else if (g == 0)
                r = mk(OP_LOAD, mf, 0, 0, 1, 0);
            else if (g == 2 || g == 3)
                r = mk(OP_STORE, mf, 0, 0, 0, g == 3);
            else if (e == 3 && g == 5) r = mk(OP_LOAD,  MF_F80, 0, 0, 1, 0);
            else if (e == 3 && g == 7) r = mk(OP_STORE, MF_F80, 0, 0, 0, 1);
            else if (e == 7 && g == 4) r = mk(OP_LOAD,  MF_BCD, 0, 0, 1, 0);
            else if (e == 7 && g == 5) r = mk(OP_LOAD,  MF_I64, 0, 0, 1, 0);
            else if (e == 7 && g == 6) r = mk(OP_STORE, MF_BCD, 0, 0, 0, 1);
            else if (e == 7 && g == 7) r = mk(OP_STORE, MF_I64, 0, 0, 0, 1);
            else if (e == 1 && g == 4) r = mk(OP_LDENV, MF_ENV, 0, 0, 0, 0);
            else if (e == 1 && g == 5) r = mk(OP_LDCW,  MF_WORD, 0, 0, 0, 0);
            else if (e == 1 && g == 6) r = mk(OP_STENV, MF_ENV, 0, 0, 0, 0);
            else if (e == 1 && g == 7) begin r = mk(OP_STCW, MF_WORD, 0, 0, 0, 0); r.cw_mem = 1'b1; end
            else if (e == 5 && g == 4) r = mk(OP_RSTOR, MF_STATE, 0, 0, 0, 0);
            else if (e == 5 && g == 6) r = mk(OP_SAVE,  MF_STATE, 0, 0, 0, 0);
            else if (e == 5 && g == 7) begin r = mk(OP_STSW, MF_WORD, 0, 0, 0, 0); r.sw_mem = 1'b1; end
        end else begin
            case (e)
                0: r = mk(fwd[g], MF_NONE, s, 0, 0, g == 3);
                1: begin
                    if (g == 0)      r = mk(OP_LOAD,  MF_NONE, s, 0, 1, 0);
                    else if (g == 1) r = mk(OP_XCH,   MF_NONE, s, 0, 0, 0);
                    else if (g == 2) r = mk(OP_NOP,   MF_NONE, 0, 0, 0, 0);
                    else if (g == 3) r = mk(OP_STORE, MF_NONE, 0, s, 0, 1);
                    else if (g == 4) begin
                        if (s == 0) r = mk(OP_CHS, MF_NONE, 0, 0, 0, 0);
                        if (s == 1) r = mk(OP_ABS, MF_NONE, 0, 0, 0, 0);
                        if (s == 4) r = mk(OP_TST, MF_NONE, 0, 0, 0, 0);
                        if (s == 5) r = mk(OP_XAM, MF_NONE, 0, 0, 0, 0);
                    end else if (g == 5) begin
                        if (s != 7) begin r = mk(OP_CONST, MF_NONE, 0, 0, 1, 0); r.func = {1'b0, s}; end
                    end else if (g == 6 && s == 6) r = mk(OP_DECTOP, MF_NONE, 0, 0, 0, 0);
                    else if (g == 6 && s == 7)     r = mk(OP_INCTOP, MF_NONE, 0, 0, 0, 0);
                    else begin r = mk(OP_TRANS, MF_NONE, 0, 0, 0, 0); r.func = {g[0], s}; end
                end
                2: if (g == 5 && s == 1) r = mk(OP_UCOM, MF_NONE, 1, 0, 0, 2);
                3: if (g == 4) begin
                    if (s == 2) r = mk(OP_CLEX, MF_NONE, 0, 0, 0, 0);
                    if (s == 3) r = mk(OP_INIT, MF_NONE, 0, 0, 0, 0);
                    if (s == 4 || s == 5) r = mk(OP_NOP, MF_NONE, 0, 0, 0, 0);
                end
                4, 6: begin
                    if (g == 2 || g == 3) r = mk(OP_COM, MF_NONE, s, 0, 0, (g == 3) + (e == 6));
                    else                  r = mk(rev[g], MF_NONE, 0, s, 0, (e == 6));
                    if (e == 6 && g == 3) begin
                        if (s == 1) r = mk(OP_COM, MF_NONE, 1, 0, 0, 2);
                        else begin r = '0; r.invalid = 1'b1; end
                    end
                end
                5: case (g)
                    0: r = mk(OP_FREE,  MF_NONE, 0, s, 0, 0);
                    1: r = mk(OP_XCH,   MF_NONE, s, 0, 0, 0);
                    2: r = mk(OP_STORE, MF_NONE, 0, s, 0, 0);
                    3: r = mk(OP_STORE, MF_NONE, 0, s, 0, 1);
                    4: r = mk(OP_UCOM,  MF_NONE, s, 0, 0, 0);
                    5: r = mk(OP_UCOM,  MF_NONE, s, 0, 0, 1);
                    default: ;
                endcase
                default: case (g)
                    0: r = mk(OP_FREE,  MF_NONE, 0, s, 0, 1);
                    1: r = mk(OP_XCH,   MF_NONE, s, 0, 0, 0);
                    2, 3: r = mk(OP_STORE, MF_NONE, 0, s, 0, 1);
                    4: if (s == 0) begin r = mk(OP_STSW, MF_NONE, 0, 0, 0, 0); r.sw_ax = 1'b1; end
                    default: ;
                endcase
            endcase
        end
        return r;
    endfunction

    function automatic string req_of(logic [2:0] e, logic m, logic [7:0] rm, dec_bundle_t x);
        if (x.invalid)                                   return "R11";
        if (x.sw_mem || x.sw_ax || x.cw_mem)             return "R9";
        if (m && !e[0])                                  return "R2";
        if (m && e == 7 && rm[5])                        return "R8";
        if (!m && e == 2)                                return "R5";
        if (!m && e == 3)                                return "R10";
        if (!m && e == 4)                                return "R3";
        if (!m && e == 6)                                return "R4";
        if (!m && e == 1 && rm[5:3] == 5)                return "R6";
        if (!m && e == 1 && rm[5:4] == 2'b11)            return "R7";
        if (!m && e == 1 && rm[5:3] == 4)                return "R7";
        if (x.push)                                      return "R13";
        return "R1";
    endfunction

    function automatic dec_bundle_t actual();
        dec_bundle_t a;
        a.op      = op_class_e'(op_class);
        a.func    = func_sel;
        a.src     = src_off;
        a.dst     = dst_off;
        a.fmt     = mem_fmt_e'(mem_fmt);
        a.push    = push_req;
        a.pops    = pop_cnt;
        a.invalid = invalid;
        a.sw_mem  = store_sw_mem;
        a.sw_ax   = store_sw_ax;
        a.cw_mem  = store_cw_mem;
        return a;
    endfunction

    task automatic check(string req, logic ov_exp, dec_bundle_t exp);
        dec_bundle_t a;
        a = actual();
        n_chk++;
        if (out_valid !== ov_exp || a !== exp) begin
            n_fail++;
            $display("FAIL %s: valid=%0b bundle=%h expected valid=%0b bundle=%h",
                     req, out_valid, a, ov_exp, exp);
        end
    endtask

    // strobe at negedge, registered at posedge, sampled at next negedge
    task automatic apply(logic [2:0] e, logic m, logic [7:0] rm);
        dec_bundle_t x;
        x = ref_dec(e, m, rm);
        esc_num  = e;
        mem_form = m;
        modrm    = rm;
        in_valid = 1'b1;
        @(negedge clk);
        check(req_of(e, m, rm, x), 1'b1, x);
        last_exp = x;
    endtask

    task automatic gap();
        esc_num  = 3'($urandom);
        modrm    = 8'($urandom);
        mem_form = 1'($urandom);
        in_valid = 1'b0;
        @(negedge clk);
        check("R12", 1'b0, last_exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        last_exp = '0;
        repeat (3) @(negedge clk);
        check("R12", 1'b0, '0);              // reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", 1'b0, '0);

        // directed corners
        apply(3'd4, 1'b0, 8'b11_100_011);    // R3 reversed subtract
        apply(3'd6, 1'b0, 8'b11_011_001);    // R4 double pop compare
        apply(3'd6, 1'b0, 8'b11_011_010);    // R4 illegal slot
        apply(3'd2, 1'b0, 8'b11_101_001);    // R5
        apply(3'd1, 1'b0, 8'b11_101_111);    // R6 sub 7 invalid
        apply(3'd1, 1'b0, 8'b11_110_110);    // R7 decrement top
        apply(3'd7, 1'b1, 8'b00_110_101);    // R8 BCD store
        apply(3'd7, 1'b0, 8'b11_100_000);    // R9 accumulator copy
        apply(3'd5, 1'b1, 8'b00_111_100);    // R9 status to memory
        apply(3'd3, 1'b0, 8'b11_100_011);    // R10 initialize
        gap();                               // R12 hold
        gap();

        // exhaustive sweep, back-to-back strobes
        for (int e = 0; e < 8; e++)
            for (int m = 0; m < 2; m++)
                for (int rm = 0; rm < 256; rm++)
                    apply(3'(e), 1'(m), 8'(rm));

        // random mix with idle gaps
        for (int i = 0; i < 2000; i++) begin
            apply(3'($urandom), 1'($urandom), 8'($urandom));
            if (($urandom % 4) == 0) gap();
        end

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule